// File: doc/BRIEF.md
# Latching BCD Seven-Segment Decoder

This block turns one binary-coded decimal digit into the seven active-high drive bits of a single seven-segment display. A hold register sits between the digit input and the glyph decoder. While the hold control is low, the register reloads from the digit input on every clock edge. While it is high, the register keeps its value, so the display stays frozen while the counter feeding it keeps running. Two instances, one for units and one for tens, give a two-digit stopwatch readout with a hold function.

Two override controls act on the output without touching the stored digit:
- Lamp test lights every segment, so the display can be checked.
- Blank turns every segment off. Toggling it lets an outside source modulate the brightness.

Lamp test wins over blank, and blank wins over the decoded digit. All pins are plain levels. The display shows a continuous value rather than passing a stream, so the block has no valid/ready handshake and no back-pressure.

Top module: `bcd_seg_decoder`

## Requirements
- R1: After reset, with lamp test low, every segment is off. Reset loads the hold register with code 15, which decodes to a dark display.
- R2: With no override active, a stored code 0 to 9 drives the decimal glyph on seg_o. Bit 6 is segment a and bit 0 is segment g, and a lit segment is 1. The patterns are 0=7E, 1=30, 2=6D, 3=79, 4=33, 5=5B, 6=5F, 7=70, 8=7F and 9=7B in hex. The digit on bcd_i shows one clock edge after it is sampled.
- R3: Stored codes 10 to 15 produce seg_o = 00 (all off).
- R4: While lamp_test_i is high, seg_o is 7F in the same cycle, whatever the other inputs are.
- R5: While blank_i is high and lamp_test_i is low, seg_o is 00 in the same cycle.
- R6: While hold_i is high, the register keeps its value, so the decoded output does not change as bcd_i changes.
- R7: When hold_i falls, the code present at the next clock edge is loaded, and the output follows bcd_i again from that edge on.
- R8: When lamp_test_i and blank_i are both high, lamp test decides the output (7F).
- R9: The overrides do not change the stored digit. When lamp test or blank is removed during a hold, the digit held before reappears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hold register |
| rst_n | input | 1 | Asynchronous active-low reset |
| bcd_i | input | 4 | Digit code to display |
| hold_i | input | 1 | High freezes the stored digit |
| lamp_test_i | input | 1 | High lights all segments |
| blank_i | input | 1 | High turns all segments off |
| seg_o | output | 7 | Segment drive, a at bit 6 through g at bit 0, active high |

## Verification
The overrides are combinational, so the effect of lamp test or blank is due in the same cycle they change. A new digit on bcd_i passes through one register, so its glyph is due after the next rising edge. The bench drives inputs just after a rising edge and advances its reference register on that same edge. It then compares on the falling edge, when both kinds of result have settled. Hold and release are checked at that same point: a code applied during a hold must leave the output unchanged, and the first edge after hold falls must bring in the live code.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  localparam int SEG_N = 7;
  localparam int CODE_W = 4;

  typedef logic [SEG_N-1:0] seg_t;
  typedef logic [CODE_W-1:0] code_t;

  // which source currently drives the segment pins
  typedef enum logic [1:0] {
    SRC_GLYPH = 2'd0,
    SRC_DARK  = 2'd1,
    SRC_LAMP  = 2'd2
  } seg_src_e;

  localparam seg_t SEG_ALL_ON  = '1;
  localparam seg_t SEG_ALL_OFF = '0;
endpackage

// File: rtl/seg7_hold_reg.sv
module seg7_hold_reg #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         freeze,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= RST_VAL;
    else if (!freeze)
      q <= d;
  end
endmodule

// File: rtl/seg7_glyph.sv
module seg7_glyph
  import seg7_pkg::*;
(
  input  code_t code,
  output seg_t  glyph
);
  // bit 6 = a ... bit 0 = g
  always_comb begin
    unique case (code)
      4'd0: glyph = 7'b1111110;
      4'd1: glyph = 7'b0110000;
      4'd2: glyph = 7'b1101101;
      4'd3: glyph = 7'b1111001;
      4'd4: glyph = 7'b0110011;
      4'd5: glyph = 7'b1011011;
      4'd6: glyph = 7'b1011111;
      4'd7: glyph = 7'b1110000;
      4'd8: glyph = 7'b1111111;
      4'd9: glyph = 7'b1111011;
      default: glyph = SEG_ALL_OFF;
    endcase
  end
endmodule

// File: rtl/seg7_override.sv
module seg7_override
  import seg7_pkg::*;
(
  input  logic lamp,
  input  logic dark,
  input  seg_t glyph,
  output seg_t seg
);
  seg_src_e src;

  always_comb begin
    if (lamp)
      src = SRC_LAMP;
    else if (dark)
      src = SRC_DARK;
    else
      src = SRC_GLYPH;
  end

  always_comb begin
    unique case (src)
      SRC_LAMP: seg = SEG_ALL_ON;
      SRC_DARK: seg = SEG_ALL_OFF;
      default:  seg = glyph;
    endcase
  end
endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
  import seg7_pkg::*;
#(
  parameter int BLANK_CODE = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bcd_i,
  input  logic       hold_i,
  input  logic       lamp_test_i,
  input  logic       blank_i,
  output logic [6:0] seg_o
);
  localparam code_t RST_CODE = code_t'(BLANK_CODE);

  code_t stored;
  seg_t  glyph;
  seg_t  seg;

  seg7_hold_reg #(.W(CODE_W), .RST_VAL(RST_CODE)) u_hold (
    .clk(clk), .rst_n(rst_n), .freeze(hold_i), .d(bcd_i), .q(stored)
  );

  seg7_glyph u_glyph (.code(stored), .glyph(glyph));

  seg7_override u_ovr (
    .lamp(lamp_test_i), .dark(blank_i), .glyph(glyph), .seg(seg)
  );

  assign seg_o = seg;
endmodule

// File: rtl/bcd_seg_decoder_chk.sv
module bcd_seg_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] bcd_i,
  input logic       hold_i,
  input logic       lamp_test_i,
  input logic       blank_i,
  input logic [6:0] seg_o
);
  // R4
  lamp_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_test_i |-> seg_o == 7'h7F);

  // R5
  blank_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_i && !lamp_test_i) |-> seg_o == 7'h00);

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hold_i) && !lamp_test_i && !blank_i &&
     !$past(lamp_test_i) && !$past(blank_i)) |-> $stable(seg_o));

  // R3
  bad_code_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(hold_i) && $past(bcd_i) > 4'd9 &&
     !lamp_test_i && !blank_i) |-> seg_o == 7'h00);

  // R2
  eight_glyph_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(hold_i) && $past(bcd_i) == 4'd8 &&
     !lamp_test_i && !blank_i) |-> seg_o == 7'h7F);

  // R7
  release_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(hold_i) ##1 (!lamp_test_i && !blank_i &&
     $past(bcd_i) == 4'd1)) |-> seg_o == 7'h30);
endmodule

bind bcd_seg_decoder bcd_seg_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bcd_i(bcd_i), .hold_i(hold_i),
  .lamp_test_i(lamp_test_i), .blank_i(blank_i), .seg_o(seg_o)
);

// File: tb/sim_bcd_seg_decoder.sv
module sim_bcd_seg_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bcd_i = 4'd0;
  logic       hold_i = 1'b0;
  logic       lamp_test_i = 1'b0;
  logic       blank_i = 1'b0;
  logic [6:0] seg_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int model_code = 15;
  bit prev_hold = 1'b0;
  bit prev_ovr = 1'b0;

  bcd_seg_decoder u0 (
    .clk(clk), .rst_n(rst_n), .bcd_i(bcd_i), .hold_i(hold_i),
    .lamp_test_i(lamp_test_i), .blank_i(blank_i), .seg_o(seg_o)
  );

  always #10 clk = ~clk;

  function automatic logic [6:0] shape(int c);
    case (c)
      0: return 7'h7E;  1: return 7'h30;  2: return 7'h6D;  3: return 7'h79;
      4: return 7'h33;  5: return 7'h5B;  6: return 7'h5F;  7: return 7'h70;
      8: return 7'h7F;  9: return 7'h7B;
      default: return 7'h00;
    endcase
  endfunction

  // reference register
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_code <= 15;
    else if (!hold_i) model_code <= int'(bcd_i);
  end

  task automatic check(string tag, logic [6:0] expv);
    total++;
    if (seg_o !== expv) begin
      bad++;
      $display("FAIL %s: seg_o=%h expected=%h t=%0t", tag, seg_o, expv, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [6:0] e;
      string tag;
      if (lamp_test_i) begin
        e = 7'h7F; tag = blank_i ? "R8" : "R4";
      end else if (blank_i) begin
        e = 7'h00; tag = "R5";
      end else begin
        e = shape(model_code);
        if (hold_i && prev_ovr) tag = "R9";
        else if (hold_i) tag = "R6";
        else if (prev_hold) tag = "R7";
        else if (model_code > 9) tag = "R3";
        else tag = "R2";
      end
      check(tag, e);
    end
    prev_hold = hold_i;
    prev_ovr = lamp_test_i | blank_i;
  end

  task automatic step(logic [3:0] c, logic h, logic lt, logic bl);
    @(posedge clk); #2;
    bcd_i = c; hold_i = h; lamp_test_i = lt; blank_i = bl;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: expired expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    total++;  // R1 reset state
    if (seg_o !== 7'h00) begin
      bad++;
      $display("FAIL R1: seg_o=%h expected=00", seg_o);
    end
    // R2, R3: sweep every code
    for (int c = 0; c < 16; c++) step(4'(c), 1'b0, 1'b0, 1'b0);
    for (int c = 15; c >= 0; c--) step(4'(c), 1'b0, 1'b0, 1'b0);
    // R6: freeze on 7, keep counting underneath
    step(4'd7, 1'b0, 1'b0, 1'b0);
    for (int c = 0; c < 10; c++) step(4'(c), 1'b1, 1'b0, 1'b0);
    // R9: overrides during hold, then removed
    step(4'd3, 1'b1, 1'b1, 1'b0);
    step(4'd4, 1'b1, 1'b0, 1'b0);
    step(4'd5, 1'b1, 1'b0, 1'b1);
    step(4'd6, 1'b1, 1'b0, 1'b0);
    step(4'd2, 1'b1, 1'b1, 1'b1);
    step(4'd2, 1'b1, 1'b0, 1'b0);
    // R7: release
    step(4'd1, 1'b0, 1'b0, 1'b0);
    step(4'd9, 1'b0, 1'b0, 1'b0);
    step(4'd4, 1'b0, 1'b0, 1'b0);
    // R4, R5, R8 with live input
    for (int c = 0; c < 12; c++) step(4'(c), 1'b0, 1'b1, 1'b0);
    for (int c = 0; c < 12; c++) step(4'(c), 1'b0, 1'b0, 1'b1);
    for (int c = 0; c < 6; c++) step(4'(c), 1'b0, 1'b1, 1'b1);
    step(4'd5, 1'b0, 1'b0, 1'b0);
    step(4'd5, 1'b0, 1'b0, 1'b0);
    // mixed pseudo-random pattern
    for (int i = 0; i < 400; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      step(r[3:0], r[4] & r[5], r[6] & r[7] & r[5], r[7] & ~r[4] & r[6]);
    end
    step(4'd0, 1'b0, 1'b0, 1'b0);
    step(4'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    #1 done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule